// File: doc/BRIEF.md
# Counted Pipelined-Loop Branch Controller

This block resolves the closing branch of a counted, modulo-scheduled loop. It keeps a 64-bit trip counter and a 64-bit drain counter. It also keeps a 48-entry rotating predicate file, which is addressed through a rotation base. Each time the branch strobe is accepted, four things happen together in one clock edge: the block decides whether the loop goes on, writes the stage-enable bit, steps the rotation base and decrements one of the two counters.

Software loads either counter through its own load strobe. It can also fill the whole predicate file in one write. That fill is applied to physical entries, whatever the current rotation base is. The outputs are:
- the 48 predicates in logical order,
- the rotation base,
- both counters,
- the taken flag with a one-cycle result strobe,
- a drain-phase indicator.

In this document, logical predicate L (16 to 63) appears on `pred_o[L-16]`. It lives in physical entry `(L-16+base) mod 48`.

Top module: `lbr_ctrl`

## Requirements
- R1: After synchronous reset, the trip count, the drain count, the base, all predicates, `taken_o` and `res_vld_o` are 0.
- R2: An accepted branch with a nonzero trip count does all of the following: it sets `taken_o`=1, decrements the trip count, leaves the drain count unchanged, and makes `pred_o[0]`=1.
- R3: Every branch that rotates does two things. It steps the base down by one, with 0 wrapping to 47. It shifts the logical view so that the new `pred_o[j+1]` equals the old `pred_o[j]` for j = 0..46.
- R4: An accepted branch with trip count 0 and drain count greater than 1 does all of the following: it sets `taken_o`=1, decrements the drain count, keeps the trip count at 0, makes `pred_o[0]`=0 and rotates.
- R5: An accepted branch with trip count 0 and drain count 1 does all of the following: it sets `taken_o`=0, takes the drain count to 0, makes `pred_o[0]`=0 and still rotates once.
- R6: An accepted branch with both counts 0 sets `taken_o`=0 and changes no predicate, no counter and not the base.
- R7: A bulk write puts data bit k into physical entry k, so the bit appears on `pred_o[(k-base) mod 48]`. The base is unchanged.
- R8: A branch strobe is ignored when it arrives in the same cycle as either counter load or a bulk write. In that case `res_vld_o` stays 0, the loads and the write take effect, and nothing rotates.
- R9: `epilog_o` is 1 exactly when the trip count is 0.
- R10: `res_vld_o` is high for one cycle, in the cycle after each accepted branch. It is never high otherwise. `taken_o` holds the result of the last accepted branch.
- R11: The counters are 64-bit unsigned. A trip count of 2^64-1 decrements to 2^64-2 without any other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_i | input | 1 | Branch-execute strobe |
| lc_ld_i | input | 1 | Trip-count load strobe |
| lc_d_i | input | 64 | Trip-count load value |
| ec_ld_i | input | 1 | Drain-count load strobe |
| ec_d_i | input | 64 | Drain-count load value |
| pinit_i | input | 1 | Bulk predicate write strobe |
| pinit_d_i | input | 48 | Bulk predicate data, bit k to physical entry k |
| pred_o | output | 48 | Predicates in logical order, bit 0 = logical 16 |
| base_o | output | 6 | Rotation base |
| lc_o | output | 64 | Trip count |
| ec_o | output | 64 | Drain count |
| taken_o | output | 1 | Result of the last accepted branch |
| res_vld_o | output | 1 | One-cycle pulse after an accepted branch |
| epilog_o | output | 1 | Drain phase (trip count is 0) |

## Verification
A wrong base or a wrong write index in the predicate file shows up on `pred_o` in the cycle right after the branch. It appears as a logical view that is not a clean one-place shift with the new stage bit at bit 0. A bulk write made while the base is nonzero shows whether the fill ignores the base: a mistake gives a pattern that is rotated on `pred_o`. A wrong phase decision or a wrong counter decrement appears one cycle after the branch, on `taken_o`, `lc_o` or `ec_o`. The exit branch and the halted branch expose off-by-one errors in the drain logic immediately.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    localparam int ROT_N     = 48;
    localparam int ROT_FIRST = 16;
    localparam int CNT_W     = 64;
    localparam int BASE_W    = $clog2(ROT_N);

    typedef enum logic [1:0] {
        PH_FILL,
        PH_DRAIN,
        PH_LAST,
        PH_HALT
    } br_kind_e;

    typedef struct packed {
        logic taken;
        logic stage;
        logic rotate;
        logic dec_lc;
        logic dec_ec;
    } br_ctl_t;

    // (a + b) mod n for small non-negative operands
    function automatic int unsigned wrap_sum(int unsigned a, int unsigned b, int unsigned n);
        return (a + b) % n;
    endfunction

    // base decremented modulo n
    function automatic int unsigned wrap_dec(int unsigned b, int unsigned n);
        return (b == 0) ? (n - 1) : (b - 1);
    endfunction

endpackage

// File: rtl/lbr_decide.sv
module lbr_decide
    import lbr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic [CW-1:0] lc_i,
    input  logic [CW-1:0] ec_i,
    output br_ctl_t       ctl_o,
    output br_kind_e      kind_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        if (lc_i != '0)       kind_o = PH_FILL;
        else if (ec_i > ONE)  kind_o = PH_DRAIN;
        else if (ec_i == ONE) kind_o = PH_LAST;
        else                  kind_o = PH_HALT;
    end

    always_comb begin
        ctl_o = '0;
        unique case (kind_o)
            PH_FILL: begin
                ctl_o.taken  = 1'b1;
                ctl_o.stage  = 1'b1;
                ctl_o.rotate = 1'b1;
                ctl_o.dec_lc = 1'b1;
            end
            PH_DRAIN: begin
                ctl_o.taken  = 1'b1;
                ctl_o.rotate = 1'b1;
                ctl_o.dec_ec = 1'b1;
            end
            PH_LAST: begin
                ctl_o.rotate = 1'b1;
                ctl_o.dec_ec = 1'b1;
            end
            default: ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/lbr_downcnt.sv
module lbr_downcnt #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    input  logic         dec_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst)        q_o <= '0;
        else if (ld_i)  q_o <= d_i;
        else if (dec_i) q_o <= q_o - W'(1);
    end

endmodule

// File: rtl/lbr_predfile.sv
module lbr_predfile
    import lbr_pkg::*;
#(
    parameter int N  = ROT_N,
    parameter int BW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_i,
    input  logic [N-1:0]  init_d_i,
    input  logic          step_i,
    input  logic          stage_i,
    output logic [N-1:0]  view_o,
    output logic [BW-1:0] base_o
);

    logic [N-1:0]  phys_q;
    logic [BW-1:0] top_idx;
    logic [BW-1:0] base_nxt;

    assign top_idx  = BW'(wrap_sum(N - 1, int'(base_o), N));
    assign base_nxt = BW'(wrap_dec(int'(base_o), N));

    always_ff @(posedge clk) begin
        if (rst) begin
            phys_q <= '0;
            base_o <= '0;
        end else if (init_i) begin
            phys_q <= init_d_i;
        end else if (step_i) begin
            phys_q[top_idx] <= stage_i;
            base_o          <= base_nxt;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_view
        logic [BW-1:0] idx;
        assign idx       = BW'(wrap_sum(k, int'(base_o), N));
        assign view_o[k] = phys_q[idx];
    end

endmodule

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
    import lbr_pkg::*;
#(
    parameter int N_P  = ROT_N,
    parameter int CW_P = CNT_W,
    parameter int BW_P = $clog2(N_P)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            br_i,
    input  logic            lc_ld_i,
    input  logic [CW_P-1:0] lc_d_i,
    input  logic            ec_ld_i,
    input  logic [CW_P-1:0] ec_d_i,
    input  logic            pinit_i,
    input  logic [N_P-1:0]  pinit_d_i,
    output logic [N_P-1:0]  pred_o,
    output logic [BW_P-1:0] base_o,
    output logic [CW_P-1:0] lc_o,
    output logic [CW_P-1:0] ec_o,
    output logic            taken_o,
    output logic            res_vld_o,
    output logic            epilog_o
);

    br_ctl_t  ctl;
    br_kind_e kind;
    logic     fire;

    // loads and bulk writes win over the branch
    assign fire = br_i & ~lc_ld_i & ~ec_ld_i & ~pinit_i;

    lbr_decide #(.CW(CW_P)) u_decide (
        .lc_i   (lc_o),
        .ec_i   (ec_o),
        .ctl_o  (ctl),
        .kind_o (kind)
    );

    lbr_downcnt #(.W(CW_P)) u_lc (
        .clk   (clk),
        .rst   (rst),
        .ld_i  (lc_ld_i),
        .d_i   (lc_d_i),
        .dec_i (fire & ctl.dec_lc),
        .q_o   (lc_o)
    );

    lbr_downcnt #(.W(CW_P)) u_ec (
        .clk   (clk),
        .rst   (rst),
        .ld_i  (ec_ld_i),
        .d_i   (ec_d_i),
        .dec_i (fire & ctl.dec_ec),
        .q_o   (ec_o)
    );

    lbr_predfile #(.N(N_P), .BW(BW_P)) u_pf (
        .clk      (clk),
        .rst      (rst),
        .init_i   (pinit_i),
        .init_d_i (pinit_d_i),
        .step_i   (fire & ctl.rotate),
        .stage_i  (ctl.stage),
        .view_o   (pred_o),
        .base_o   (base_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_o   <= 1'b0;
            res_vld_o <= 1'b0;
        end else begin
            res_vld_o <= fire;
            if (fire) taken_o <= ctl.taken;
        end
    end

    assign epilog_o = (kind != PH_FILL);

endmodule

// File: rtl/lbr_ctrl_chk.sv
module lbr_ctrl_chk #(
    parameter int N_P  = 48,
    parameter int CW_P = 64,
    parameter int BW_P = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            br_i,
    input logic            lc_ld_i,
    input logic [CW_P-1:0] lc_d_i,
    input logic            ec_ld_i,
    input logic            pinit_i,
    input logic [N_P-1:0]  pred_o,
    input logic [BW_P-1:0] base_o,
    input logic [CW_P-1:0] lc_o,
    input logic [CW_P-1:0] ec_o,
    input logic            taken_o,
    input logic            res_vld_o
);

    logic acc;
    assign acc = br_i && !lc_ld_i && !ec_ld_i && !pinit_i;

    localparam logic [CW_P-1:0] C1 = CW_P'(1);

    a_r2_fill: assert property (@(posedge clk) disable iff (rst)
        acc && lc_o != '0 |=> taken_o && res_vld_o && pred_o[0]
            && lc_o == $past(lc_o) - C1 && ec_o == $past(ec_o));

    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        acc && (lc_o != '0 || ec_o != '0) |=> pred_o[N_P-1:1] == $past(pred_o[N_P-2:0])
            && base_o == (($past(base_o) == '0) ? BW_P'(N_P - 1) : $past(base_o) - BW_P'(1)));

    a_r4_drain: assert property (@(posedge clk) disable iff (rst)
        acc && lc_o == '0 && ec_o > C1 |=> taken_o && !pred_o[0]
            && lc_o == '0 && ec_o == $past(ec_o) - C1);

    a_r5_exit: assert property (@(posedge clk) disable iff (rst)
        acc && lc_o == '0 && ec_o == C1 |=> !taken_o && res_vld_o && !pred_o[0] && ec_o == '0);

    a_r6_halt: assert property (@(posedge clk) disable iff (rst)
        acc && lc_o == '0 && ec_o == '0 |=> !taken_o && $stable(pred_o) && $stable(base_o)
            && lc_o == '0 && ec_o == '0);

    a_r7_base_kept: assert property (@(posedge clk) disable iff (rst)
        pinit_i |=> $stable(base_o));

    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        lc_ld_i |=> lc_o == $past(lc_d_i));

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !res_vld_o);

endmodule

bind lbr_ctrl lbr_ctrl_chk #(.N_P(N_P), .CW_P(CW_P), .BW_P(BW_P)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .br_i      (br_i),
    .lc_ld_i   (lc_ld_i),
    .lc_d_i    (lc_d_i),
    .ec_ld_i   (ec_ld_i),
    .pinit_i   (pinit_i),
    .pred_o    (pred_o),
    .base_o    (base_o),
    .lc_o      (lc_o),
    .ec_o      (ec_o),
    .taken_o   (taken_o),
    .res_vld_o (res_vld_o)
);

// File: tb/lbr_ctrl_tb_top.sv
`timescale 1ns/1ps
module lbr_ctrl_tb_top;

    localparam int N = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          br_i = 1'b0;
    logic          lc_ld_i = 1'b0;
    logic [63:0]   lc_d_i = '0;
    logic          ec_ld_i = 1'b0;
    logic [63:0]   ec_d_i = '0;
    logic          pinit_i = 1'b0;
    logic [N-1:0]  pinit_d_i = '0;
    logic [N-1:0]  pred_o;
    logic [5:0]    base_o;
    logic [63:0]   lc_o;
    logic [63:0]   ec_o;
    logic          taken_o;
    logic          res_vld_o;
    logic          epilog_o;

    always #10 clk = ~clk;

    lbr_ctrl dut_i (
        .clk(clk), .rst(rst), .br_i(br_i),
        .lc_ld_i(lc_ld_i), .lc_d_i(lc_d_i),
        .ec_ld_i(ec_ld_i), .ec_d_i(ec_d_i),
        .pinit_i(pinit_i), .pinit_d_i(pinit_d_i),
        .pred_o(pred_o), .base_o(base_o), .lc_o(lc_o), .ec_o(ec_o),
        .taken_o(taken_o), .res_vld_o(res_vld_o), .epilog_o(epilog_o)
    );

    typedef struct {
        string        tag;
        logic         taken;
        logic [63:0]  lc;
        logic [63:0]  ec;
        logic [5:0]   base;
        logic [N-1:0] pred;
    } exp_t;

    exp_t q[$];

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [63:0]  m_lc   = '0;
    logic [63:0]  m_ec   = '0;
    int           m_base = 0;
    logic [N-1:0] m_log  = '0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic void m_rot(logic s);
        m_log  = {m_log[N-2:0], s};
        m_base = (m_base == 0) ? N - 1 : m_base - 1;
    endfunction

    function automatic logic m_step();
        logic t;
        if (m_lc != 0) begin
            t = 1'b1; m_lc = m_lc - 1; m_rot(1'b1);
        end else if (m_ec > 1) begin
            t = 1'b1; m_ec = m_ec - 1; m_rot(1'b0);
        end else if (m_ec == 1) begin
            t = 1'b0; m_ec = '0; m_rot(1'b0);
        end else begin
            t = 1'b0;
        end
        return t;
    endfunction

    function automatic void m_init(logic [N-1:0] d);
        for (int k = 0; k < N; k++) m_log[(k - m_base + N) % N] = d[k];
    endfunction

    task automatic chk_state(string tag);
        chk({tag, " lc"},     lc_o,           m_lc);
        chk({tag, " ec"},     ec_o,           m_ec);
        chk({tag, " base"},   64'(base_o),    64'(m_base));
        chk({tag, " pred"},   64'(pred_o),    64'(m_log));
        chk("R9 epilog",      64'(epilog_o),  64'(m_lc == 0));
    endtask

    task automatic do_br(string tag);
        exp_t e;
        @(negedge clk);
        e.tag   = tag;
        e.taken = m_step();
        e.lc    = m_lc;
        e.ec    = m_ec;
        e.base  = 6'(m_base);
        e.pred  = m_log;
        q.push_back(e);
        br_i = 1'b1;
        @(negedge clk);
        br_i = 1'b0;
    endtask

    task automatic do_load(logic [63:0] l, logic [63:0] c, logic with_br);
        @(negedge clk);
        lc_ld_i = 1'b1; lc_d_i = l;
        ec_ld_i = 1'b1; ec_d_i = c;
        br_i    = with_br;
        @(negedge clk);
        lc_ld_i = 1'b0; ec_ld_i = 1'b0; br_i = 1'b0;
        m_lc = l; m_ec = c;
    endtask

    task automatic do_init(logic [N-1:0] d, logic with_br);
        @(negedge clk);
        pinit_i = 1'b1; pinit_d_i = d; br_i = with_br;
        @(negedge clk);
        pinit_i = 1'b0; br_i = 1'b0;
        m_init(d);
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && res_vld_o) begin
                if (q.size() == 0) begin
                    chk("R10 unexpected result", 64'(res_vld_o), 64'd0);
                end else begin
                    e = q.pop_front();
                    chk({e.tag, " taken"}, 64'(taken_o), 64'(e.taken));
                    chk({e.tag, " lc"},    lc_o, e.lc);
                    chk({e.tag, " ec"},    ec_o, e.ec);
                    chk("R3 base",         64'(base_o), 64'(e.base));
                    chk("R3 pred",         64'(pred_o), 64'(e.pred));
                    chk("R9 epilog",       64'(epilog_o), 64'(e.lc == 0));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 lc",    lc_o, 64'd0);
        chk("R1 ec",    ec_o, 64'd0);
        chk("R1 base",  64'(base_o), 64'd0);
        chk("R1 pred",  64'(pred_o), 64'd0);
        chk("R1 taken", 64'(taken_o), 64'd0);
        chk("R1 valid", 64'(res_vld_o), 64'd0);

        do_load(64'd2, 64'd3, 1'b0);
        chk_state("R8 load");
        do_br("R2 fill");          // base 0 -> 47 wrap (R3)
        do_br("R2 fill");
        do_br("R4 drain");
        do_br("R4 drain");
        do_br("R5 exit");
        do_br("R6 halt");
        chk_state("R6 after halt");

        do_init(48'h9ABC_DEF0_1357, 1'b0);
        chk_state("R7 bulk");

        // R8: load together with a branch strobe
        do_load(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 1'b1);
        chk("R8 no result", 64'(res_vld_o), 64'd0);
        chk_state("R8 load wins");

        do_br("R11 wide");
        do_br("R2 fill");

        // R8: bulk write together with a branch strobe
        do_init(48'h0F0F_0000_A5A5, 1'b1);
        chk("R8 no result init", 64'(res_vld_o), 64'd0);
        chk_state("R8 init wins");

        do_load(64'd0, 64'd1, 1'b0);
        do_br("R5 exit");
        do_br("R6 halt");
        chk_state("R6 final");

        repeat (3) @(negedge clk);
        chk("R10 queue drained", 64'(q.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule